// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block gathers the interrupt events of a bus communication peripheral into one active-low request line. There are eight event sources: an error summary, a bus wakeup, three transmit-buffer-empty events, two receive-buffer-full events and a message error. Each source has a latched flag bit and an enable bit. The protocol engine reports each event as a single-cycle pulse. It also drives a level that stays high while the cause of the event is still present.

A host reads and writes three 8-bit registers: enable, flag and status. A write can be a plain write, or a masked bit-modify in which only the bits selected by a mask take the new data. The host clears flags with a bit-modify without disturbing other flags. The host can also set flags itself to raise a software interrupt.

A 3-bit code names the most urgent pending source that is enabled. Lower codes win, and zero means nothing is coded. The message-error source can raise the line but has no code of its own.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the enable and flag registers are 0x00, `irq_n` is 1 and `irq_code` is 000.
- R2: A pulse on `ev_set[i]` sets flag bit i on the next clock edge, whatever the enable bit is. A flag whose enable bit is 0 affects neither `irq_n` nor `irq_code`.
- R3: `irq_n` is 0 while at least one flag bit has its enable bit set. It returns to 1 only once every such flag has been cleared or disabled.
- R4: The flag and enable bit layout is: bit0 error, bit1 wakeup, bit2 transmit 0, bit3 transmit 1, bit4 transmit 2, bit5 receive 0, bit6 receive 1, bit7 message error. `irq_code` equals i+1, where i is the lowest enabled pending bit among bits 0..6, and it is 000 when there is none.
- R5: A plain write (`host_wr`=1, `host_bitmod`=0) loads `host_wdata` into the enable register at address 0 or the flag register at address 1. Setting a flag bit by write raises `irq_n` low when its enable bit is 1.
- R6: A bit-modify write (`host_wr`=1, `host_bitmod`=1) changes only the bits where `host_mask` is 1, taking them from `host_wdata`. All other bits keep their value.
- R7: While `ev_hold[i]` is 1, a set flag bit i cannot be cleared by any host write; it stays 1.
- R8: When `ev_set[i]` pulses in the same cycle as a host write that clears bit i, the flag ends up set.
- R9: The message-error flag (bit7), when enabled, drives `irq_n` low but never produces a nonzero `irq_code`.
- R10: The status register at address 2 reads `irq_code` in bits 3:1, with every other bit 0. Writes to it change nothing. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_bitmod | input | 1 | Qualifies a write as a masked bit-modify |
| host_addr | input | 2 | Register address: 0 enable, 1 flag, 2 status |
| host_wdata | input | 8 | Write data |
| host_mask | input | 8 | Bit-modify mask, 1 selects the bit |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| ev_set | input | 8 | Single-cycle event pulses, one per source |
| ev_hold | input | 8 | Levels marking a still-present event condition |
| irq_n | output | 1 | Active-low interrupt request |
| irq_code | output | 3 | Highest-priority enabled pending source code |

## Verification
The bound checker watches these rules on every cycle:
- an enabled event always pulls the line low in the next cycle;
- the line only rises with no enabled flag left;
- a nonzero code always points at an enabled set flag;
- a held condition survives any clear;
- a same-cycle event beats a host clear;
- status writes leave the enable register alone.

Only the bench scenarios can show the full priority walk as the top source is cleared in turn, the exact read-back layout of the status register, and the register values after mixed writes. The same holds for the message error raising the line with code zero.

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC     = 8,
  parameter int AW       = 2,
  parameter int ADDR_EN  = 0,
  parameter int ADDR_FLG = 1,
  parameter int ADDR_STS = 2,
  localparam int CW      = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            host_bitmod,
  input  logic [AW-1:0]   host_addr,
  input  logic [NSRC-1:0] host_wdata,
  input  logic [NSRC-1:0] host_mask,
  output logic [NSRC-1:0] host_rdata,
  input  logic [NSRC-1:0] ev_set,
  input  logic [NSRC-1:0] ev_hold,
  output logic            irq_n,
  output logic [CW-1:0]   irq_code
);

  logic [NSRC-1:0] en_q, flg_q, pend;
  logic [NSRC-1:0] en_wr, flg_wr, flg_base;
  logic            wr_en, wr_flg;

  assign wr_en  = host_wr && (host_addr == AW'(ADDR_EN));
  assign wr_flg = host_wr && (host_addr == AW'(ADDR_FLG));

  assign en_wr  = host_bitmod ? ((en_q  & ~host_mask) | (host_wdata & host_mask)) : host_wdata;
  assign flg_wr = host_bitmod ? ((flg_q & ~host_mask) | (host_wdata & host_mask)) : host_wdata;

  assign flg_base = wr_flg ? flg_wr : flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      if (wr_en) en_q <= en_wr;
      flg_q <= flg_base | ev_set | (flg_q & ev_hold);
    end
  end

  assign pend  = flg_q & en_q;
  assign irq_n = ~|pend;

  always_comb begin
    irq_code = '0;
    for (int i = NSRC - 2; i >= 0; i--)
      if (pend[i]) irq_code = CW'(i + 1);
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == AW'(ADDR_EN))       host_rdata = en_q;
    else if (host_addr == AW'(ADDR_FLG)) host_rdata = flg_q;
    else if (host_addr == AW'(ADDR_STS)) host_rdata[CW:1] = irq_code;
  end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic [1:0] host_addr,
  input logic [7:0] ev_set,
  input logic [7:0] ev_hold,
  input logic [7:0] en_q,
  input logic [7:0] flg_q,
  input logic       irq_n,
  input logic [2:0] irq_code
);

  // R2
  enabled_event_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_set & en_q) && !host_wr) |=> !irq_n);

  // R3
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> ((flg_q & en_q) == 8'h00));

  // R4
  code_points_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_code != 3'd0) |-> (flg_q[irq_code - 3'd1] && en_q[irq_code - 3'd1]));

  // R9
  merr_uncoded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((flg_q & en_q) == 8'h80) |-> (irq_code == 3'd0 && !irq_n));

  // R7
  held_flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flg_q & ev_hold)) |=> (($past(flg_q & ev_hold) & ~flg_q) == 8'h00));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_set) |=> (($past(ev_set) & ~flg_q) == 8'h00));

  // R10
  status_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd2) |=> $stable(en_q));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .ev_set(ev_set), .ev_hold(ev_hold), .en_q(en_q), .flg_q(flg_q),
  .irq_n(irq_n), .irq_code(irq_code)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       host_wr = 0, host_bitmod = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0, host_mask = 0, ev_set = 0, ev_hold = 0;
  logic [7:0] host_rdata;
  logic       irq_n;
  logic [2:0] irq_code;

  irq_prio_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int kind; logic [7:0] val; string req; } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  initial forever begin
    @(posedge clk); #1;
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = host_rdata;
        1: act = {7'd0, irq_n};
        default: act = {5'd0, irq_code};
      endcase
      n_chk++;
      if (act !== it.val) begin
        n_fail++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.val);
      end
    end
  end

  task automatic expect_v(input int kind, input logic [7:0] v, input string req);
    item_t it;
    it.kind = kind; it.val = v; it.req = req;
    q.push_back(it);
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] v, input string req);
    host_addr = a;
    expect_v(0, v, req);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [7:0] m,
                    input logic bm, input logic [7:0] ev);
    @(negedge clk);
    host_wr = 1; host_bitmod = bm; host_addr = a; host_wdata = d; host_mask = m; ev_set = ev;
    @(negedge clk);
    host_wr = 0; host_bitmod = 0; ev_set = 0;
  endtask

  task automatic pulse(input logic [7:0] ev);
    @(negedge clk); ev_set = ev;
    @(negedge clk); ev_set = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, 8'h00, "R1"); rd(1, 8'h00, "R1"); rd(2, 8'h00, "R1");
    expect_v(1, 8'h01, "R1"); expect_v(2, 8'h00, "R1");
    // R2 event with enable off
    pulse(8'h08);
    rd(1, 8'h08, "R2"); expect_v(1, 8'h01, "R2"); expect_v(2, 8'h00, "R2");
    // R5 enable write, R4 code
    wr(0, 8'hFF, 8'h00, 0, 8'h00);
    rd(0, 8'hFF, "R5"); expect_v(1, 8'h00, "R3"); expect_v(2, 8'h04, "R4");
    rd(2, 8'h08, "R10");
    pulse(8'h01);
    expect_v(2, 8'h01, "R4"); rd(2, 8'h02, "R10");
    // R6 bit-modify clear of error only
    wr(1, 8'h00, 8'h01, 1, 8'h00);
    rd(1, 8'h08, "R6"); expect_v(2, 8'h04, "R4");
    // R9 message error only
    wr(1, 8'h80, 8'h00, 0, 8'h00);
    rd(1, 8'h80, "R5"); expect_v(1, 8'h00, "R9"); expect_v(2, 8'h00, "R9");
    wr(1, 8'h00, 8'h00, 0, 8'h00);
    expect_v(1, 8'h01, "R3");
    // R7 held condition
    @(negedge clk); ev_hold = 8'h20;
    pulse(8'h20);
    wr(1, 8'h00, 8'h20, 1, 8'h00);
    rd(1, 8'h20, "R7"); expect_v(2, 8'h06, "R7");
    wr(1, 8'h00, 8'h00, 0, 8'h00);
    rd(1, 8'h20, "R7");
    ev_hold = 8'h00;
    wr(1, 8'h00, 8'h20, 1, 8'h00);
    rd(1, 8'h00, "R7"); expect_v(1, 8'h01, "R3");
    // R8 set beats same-cycle clear
    wr(1, 8'h00, 8'h04, 1, 8'h04);
    rd(1, 8'h04, "R8");
    // R6 event on another bit during a bit-modify is kept
    wr(1, 8'h00, 8'h04, 1, 8'h02);
    rd(1, 8'h02, "R6"); expect_v(2, 8'h02, "R4");
    // R10 status write ignored
    wr(2, 8'h00, 8'h00, 0, 8'h00);
    rd(0, 8'hFF, "R10"); rd(1, 8'h02, "R10");
    // R4 priority walk
    wr(1, 8'h52, 8'h00, 0, 8'h00);
    expect_v(2, 8'h02, "R4");
    wr(1, 8'h00, 8'h02, 1, 8'h00);
    expect_v(2, 8'h05, "R4");
    wr(1, 8'h00, 8'h10, 1, 8'h00);
    expect_v(2, 8'h07, "R4"); rd(2, 8'h0E, "R10");
    wr(1, 8'h00, 8'h40, 1, 8'h00);
    expect_v(2, 8'h00, "R4"); expect_v(1, 8'h01, "R3");
    // R2 disabling a source moves the code
    wr(1, 8'h05, 8'h00, 0, 8'h00);
    expect_v(2, 8'h01, "R4");
    wr(0, 8'h00, 8'h01, 1, 8'h00);
    rd(0, 8'hFE, "R6"); expect_v(2, 8'h03, "R2");
    rd(3, 8'h00, "R10");
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule